// File: doc/BRIEF.md
# Single-Precision Compare Condition Code Unit

This block compares two single-precision IEEE-754 operands and returns a two-bit condition code that tells whether the first operand is equal to, below, above, or unordered with the second. The result is registered, so the code appears one cycle after the operands are offered, together with a one-cycle valid strobe.

A mode input selects one of two compare flavours. In quiet mode the invalid-operation flag is raised only when a signalling NaN is present. In signalling mode the flag is raised whenever either operand is any NaN. The invalid flag has the same form as the flags that the arithmetic units produce, so the status unit can apply the same trap-enable test and the same accrual to it.

The block also drives a separate strobe for every unordered result, in either mode. The status unit uses this strobe to set its accrued-invalid bit directly. This strobe is in addition to the normal invalid flag.

Top module: `fcmp_cc_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, out_invalid and out_accrue_inv are 0 and out_cc is 0.
- R2: out_valid is high in exactly the cycle that follows a cycle with in_valid high, and low otherwise; results come out in issue order.
- R3: out_cc encodes the relation of opa to opb as 0 = equal, 1 = opa less than opb, 2 = opa greater than opb, 3 = unordered.
- R4: +0 (0x00000000) and -0 (0x80000000) compare as equal, in any pairing.
- R5: Non-NaN operands of different sign are ordered by the sign bit (bit 31, set = negative). Non-NaN operands of the same sign are ordered by magnitude (bits 30:0), and the order is reversed when both are negative. Infinities take part as the largest magnitudes.
- R6: An operand is a NaN when its exponent (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. A compare involving any NaN yields code 3.
- R7: With signaling = 0 (quiet), out_invalid is 1 only when at least one operand is a signalling NaN, which is a NaN with fraction bit 22 clear. A quiet NaN (bit 22 set) alone leaves it 0.
- R8: With signaling = 1, out_invalid is 1 whenever either operand is a NaN of either kind.
- R9: out_accrue_inv is 1 for every valid result with code 3, in both modes, and 0 for every ordered result.
- R10: out_invalid and out_accrue_inv are 0 in every cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| signaling | input | 1 | 1 = signalling compare, 0 = quiet compare |
| opa | input | 32 | First operand, single-precision bit pattern |
| opb | input | 32 | Second operand, single-precision bit pattern |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_cc | output | 2 | Condition code (0 eq, 1 lt, 2 gt, 3 unordered) |
| out_invalid | output | 1 | Invalid-operation flag for the status unit |
| out_accrue_inv | output | 1 | Direct set of the accrued-invalid bit on unordered results |

## Verification
Some properties are checked on every cycle. The timing of the valid strobe, the absence of flags without a valid result, and the tie between code 3 and the accrue strobe are checked this way. So are the rule that ordered results never raise invalid, the rule that signalling mode always raises invalid on an unordered result, and the rule that signed zeros compare equal. Other behaviour depends on knowing the operand values, so only the bench scenarios can show it. This covers the ordering of same-sign negatives, infinities against the largest finite values, subnormals, and the split between quiet and signalling NaNs in quiet mode.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } cc_t;

    typedef struct packed {
        logic sign;
        logic zero;
        logic nan;
        logic snan;
    } fp_kind_t;

    // Relation of two ordered magnitudes, taking the common sign into account
    function automatic cc_t mag_rel(input logic lt, input logic eq, input logic neg);
        if (eq)
            return CC_EQ;
        else if (lt ^ neg)
            return CC_LT;
        else
            return CC_GT;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    output fp_kind_t     kind
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = op[W-2 -: EXP_W];
    assign frac_f = op[FRAC_W-1:0];

    always_comb begin
        kind.sign = op[W-1];
        kind.zero = (exp_f == '0) && (frac_f == '0);
        kind.nan  = (&exp_f) && (frac_f != '0);
        kind.snan = kind.nan && !frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  fp_kind_t         ka,
    input  fp_kind_t         kb,
    input  logic [MAG_W-1:0] ma,
    input  logic [MAG_W-1:0] mb,
    output cc_t              rel
);
    logic mag_lt, mag_eq;

    assign mag_lt = ma < mb;
    assign mag_eq = ma == mb;

    always_comb begin
        if (ka.nan || kb.nan)
            rel = CC_UN;
        else if (ka.zero && kb.zero)
            rel = CC_EQ;
        else if (ka.sign != kb.sign)
            rel = ka.sign ? CC_LT : CC_GT;
        else
            rel = mag_rel(mag_lt, mag_eq, ka.sign);
    end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
(
    input  fp_kind_t ka,
    input  fp_kind_t kb,
    input  logic     signaling,
    input  cc_t      rel,
    output logic     invalid,
    output logic     accrue
);
    always_comb begin
        if (signaling)
            invalid = ka.nan || kb.nan;
        else
            invalid = ka.snan || kb.snan;
        accrue = (rel == CC_UN);
    end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int MAG_W = W - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         signaling,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         out_valid,
    output logic [1:0]   out_cc,
    output logic         out_invalid,
    output logic         out_accrue_inv
);
    logic [1:0][W-1:0] ops;
    fp_kind_t [1:0]    kinds;
    cc_t               rel_c;
    logic              inv_c, acc_c;

    cc_t  cc_q;
    logic vld_q, inv_q, acc_q;

    assign ops[0] = opa;
    assign ops[1] = opb;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op   (ops[i]),
            .kind (kinds[i])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .ka  (kinds[0]),
        .kb  (kinds[1]),
        .ma  (opa[MAG_W-1:0]),
        .mb  (opb[MAG_W-1:0]),
        .rel (rel_c)
    );

    fcmp_flags u_flg (
        .ka        (kinds[0]),
        .kb        (kinds[1]),
        .signaling (signaling),
        .rel       (rel_c),
        .invalid   (inv_c),
        .accrue    (acc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cc_q  <= CC_EQ;
            inv_q <= 1'b0;
            acc_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            inv_q <= in_valid && inv_c;
            acc_q <= in_valid && acc_c;
            if (in_valid)
                cc_q <= rel_c;
        end
    end

    assign out_valid      = vld_q;
    assign out_cc         = cc_q;
    assign out_invalid    = inv_q;
    assign out_accrue_inv = acc_q;
endmodule

// File: rtl/fcmp_cc_checker.sv
module fcmp_cc_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        signaling,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic        out_valid,
    input logic [1:0]  out_cc,
    input logic        out_invalid,
    input logic        out_accrue_inv
);
    // R2
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_invalid && !out_accrue_inv));
    // R9
    a_r9_unordered_accrues: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cc == 2'd3) |-> out_accrue_inv);
    // R9
    a_r9_accrue_only_unordered: assert property (@(posedge clk) disable iff (rst)
        out_accrue_inv |-> (out_valid && out_cc == 2'd3));
    // R7 and R8: no NaN, no invalid
    a_r7_ordered_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cc != 2'd3) |-> !out_invalid);
    // R8
    a_r8_signal_mode_invalid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && signaling && (opa[30:23] == 8'hFF) && (opa[22:0] != 0))
        |=> (out_invalid && out_cc == 2'd3));
    // R4
    a_r4_signed_zero_equal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opa[30:0] == 0 && opb[30:0] == 0) |=> (out_cc == 2'd0));
endmodule

bind fcmp_cc_unit fcmp_cc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .signaling      (signaling),
    .opa            (opa),
    .opb            (opb),
    .out_valid      (out_valid),
    .out_cc         (out_cc),
    .out_invalid    (out_invalid),
    .out_accrue_inv (out_accrue_inv)
);

// File: tb/sim_fcmp_cc_unit.sv
module sim_fcmp_cc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        signaling = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [1:0]  out_cc;
    logic        out_invalid;
    logic        out_accrue_inv;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic [1:0] cc;
        logic       inv;
        logic       acc;
    } exp_t;

    exp_t       sb_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    fcmp_cc_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .signaling(signaling),
        .opa(opa), .opb(opb), .out_valid(out_valid), .out_cc(out_cc),
        .out_invalid(out_invalid), .out_accrue_inv(out_accrue_inv)
    );

    // Reference model written from the requirements: signed-key ordering
    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic sig);
        exp_t e;
        logic na, nb, sa, sb;
        logic signed [33:0] ka, kb;
        na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        sa = na && !a[22];
        sb = nb && !b[22];
        ka = a[31] ? -$signed({3'b0, a[30:0]}) : $signed({3'b0, a[30:0]});
        kb = b[31] ? -$signed({3'b0, b[30:0]}) : $signed({3'b0, b[30:0]});
        if (na || nb)     e.cc = 2'd3;
        else if (ka < kb) e.cc = 2'd1;
        else if (ka > kb) e.cc = 2'd2;
        else              e.cc = 2'd0;
        e.inv = sig ? (na || nb) : (sa || sb);
        e.acc = (na || nb);
        return e;
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic sig, input string tag);
        @(negedge clk);
        opa = a; opb = b; signaling = sig; in_valid = 1'b1;
        sb_q.push_back(model(a, b, sig));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: checks results against the scoreboard away from the clock edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected out_valid actual 1 expected 0");
                end else begin
                    exp_t e;
                    string t;
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if ({out_cc, out_invalid, out_accrue_inv} !== e) begin
                        errors++;
                        $display("FAIL %s actual cc=%0d inv=%0d acc=%0d expected cc=%0d inv=%0d acc=%0d",
                                 t, out_cc, out_invalid, out_accrue_inv, e.cc, e.inv, e.acc);
                    end
                end
            end else begin
                checks++;
                if (out_invalid !== 1'b0 || out_accrue_inv !== 1'b0) begin
                    errors++;
                    $display("FAIL R10 flags while idle actual inv=%0d acc=%0d expected 0 0",
                             out_invalid, out_accrue_inv);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, out_cc, out_invalid, out_accrue_inv} !== 5'b0) begin
            errors++;
            $display("FAIL R1 reset state actual %b expected 00000",
                     {out_valid, out_cc, out_invalid, out_accrue_inv});
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({out_valid, out_cc, out_invalid, out_accrue_inv} !== 5'b0) begin
            errors++;
            $display("FAIL R1 after reset actual %b expected 00000",
                     {out_valid, out_cc, out_invalid, out_accrue_inv});
        end

        drive(32'h3F800000, 32'h3F800000, 1'b0, "R3 equal");
        drive(32'h3F800000, 32'h40000000, 1'b0, "R3 less");
        drive(32'h40000000, 32'h3F800000, 1'b1, "R3 greater");
        drive(32'h00000000, 32'h80000000, 1'b0, "R4 +0 vs -0");
        drive(32'h80000000, 32'h00000000, 1'b1, "R4 -0 vs +0");
        idle(2);
        drive(32'hBF800000, 32'h3F800000, 1'b0, "R5 mixed sign");
        drive(32'hC0000000, 32'hBF800000, 1'b0, "R5 negatives reversed");
        drive(32'hBF800000, 32'hC0000000, 1'b0, "R5 negatives reversed gt");
        drive(32'h7F800000, 32'h7F7FFFFF, 1'b0, "R5 inf above max");
        drive(32'hFF800000, 32'h00000001, 1'b0, "R5 -inf below subnormal");
        drive(32'h7F800000, 32'h7F800000, 1'b1, "R6 inf is ordered");
        drive(32'h7FC00000, 32'h3F800000, 1'b0, "R7 quiet qNaN no invalid");
        drive(32'h3F800000, 32'h7F800001, 1'b0, "R7 quiet sNaN invalid");
        drive(32'hFFC00000, 32'h00000000, 1'b1, "R8 signaling qNaN invalid");
        drive(32'h7FA00000, 32'hFF800000, 1'b1, "R8 signaling sNaN invalid");
        drive(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, "R9 qNaN pair accrue");
        idle(3);

        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = (i % 5 == 0) ? {~a[31], a[30:0]} : lfsr;
            if (i % 7 == 0) a[30:23] = 8'hFF;
            drive(a, b, lfsr[3], "R5 R6 R7 R8 sweep");
            if (i % 11 == 0) idle(1);
        end
        idle(3);

        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing results actual %0d expected 0", sb_q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule